// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Tracker

This block follows the low-power state of an SDRAM device as a memory controller sees it. At every rising clock edge it combines the clock-enable level on that edge, the level it stored on the edge before, the decoded command on the bus and an access-active hint. From these it works out whether the device is idle, busy with an access, powered down, in self-refresh, in clock suspend, or in the recovery interval after self-refresh.

It gives a one-hot state vector and single-cycle pulses that mark entry into and exit from each low-power mode. It also has two sticky flags. One marks an illegal combination of state, clock-enable pair and command. The other marks a breach of the self-refresh exit recovery rules. A controller or monitor uses these outputs to confirm that its own sequencing of the clock-enable pin stays legal.

Top module: `sdram_cke_tracker`

## Requirements
- R1: A synchronous active-high reset drives the state vector to idle (bit 0), clears both event vectors and both flags, and stores the previous clock-enable level as high. The first edge after reset therefore treats a low clock-enable as a high-to-low transition.
- R2: When the clock-enable level is low on both the previous and the present edge, a block in power-down, self-refresh or clock suspend keeps that state and ignores the command, including auto refresh.
- R3: From idle, a high-to-low clock-enable edge with command inhibit (code 0) or NOP (code 1) enters power-down (state bit 2). From power-down, a low-to-high edge with inhibit or NOP returns to idle, and idle is shown right after that edge.
- R4: From idle, a high-to-low clock-enable edge with auto refresh (code 2) enters self-refresh (state bit 3).
- R5: From self-refresh, a low-to-high edge with inhibit or NOP enters recovery (state bit 5). The block then stays in recovery for the next TXSR_CYC edges that have clock-enable high on both samples, and it shows idle after the last of them.
- R6: The violation flag is set and stays set until reset if either of two things happens on a recovery window edge. One is a command other than inhibit or NOP. The other is that fewer than two NOP commands have been seen across the window when its last edge arrives. The exit edge itself is not part of the window.
- R7: From access (state bit 1), a high-to-low edge with any command except inhibit enters clock suspend (state bit 4). A low-to-high edge from clock suspend with any command returns to access.
- R8: With clock-enable high on both samples, in idle or access, the next state is access when access_active is 1 and idle otherwise.
- R9: Any other combination of state, clock-enable pair and command sets the illegal flag and holds the state. The flag stays set until reset. Command codes 3 to 7 all count as other valid commands.
- R10: The enter and exit event vectors use bit 0 for power-down, bit 1 for self-refresh and bit 2 for clock suspend. Each pulse is high for the one cycle that follows the edge where the transition happens. At most one event bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level driven to the device |
| cmd | input | 3 | Decoded command: 0 inhibit, 1 NOP, 2 auto refresh, 3-7 other valid |
| access_active | input | 1 | High when a read or write is in progress |
| pwr_state | output | 6 | One-hot: idle, access, power-down, self-refresh, clock suspend, recovery (bits 0 to 5) |
| enter_evt | output | 3 | Mode entry pulses: power-down, self-refresh, clock suspend |
| exit_evt | output | 3 | Mode exit pulses, same bit order |
| illegal_seq | output | 1 | Sticky flag for an illegal combination |
| xsr_violation | output | 1 | Sticky flag for a recovery window breach |

## Verification
Every output is a register, so the effect of inputs sampled on a given edge is visible right after that same edge. The bench drives inputs on the falling edge and compares them 1 ns after the next rising edge against a reference model. That model has been advanced by exactly one step. Idle after self-refresh exit appears only after the TXSR_CYC-th window edge, so the bench checks every intermediate cycle of the window as recovery. A violation is checked on the edge that causes it, and on every cycle after that, to confirm it is sticky.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  // command codes as seen on the decoded command input
  localparam logic [2:0] CMD_INHIBIT = 3'd0;
  localparam logic [2:0] CMD_NOP     = 3'd1;
  localparam logic [2:0] CMD_AREF    = 3'd2;

  localparam int NUM_MODES = 3;
  localparam int EV_PD = 0;
  localparam int EV_SR = 1;
  localparam int EV_CS = 2;

  typedef enum logic [1:0] {
    CC_INHIBIT = 2'd0,
    CC_NOP     = 2'd1,
    CC_AREF    = 2'd2,
    CC_OTHER   = 2'd3
  } cmd_class_t;

  // {previous, present} clock-enable sample
  typedef enum logic [1:0] {
    PAIR_LL = 2'b00,
    PAIR_LH = 2'b01,
    PAIR_HL = 2'b10,
    PAIR_HH = 2'b11
  } cke_pair_t;

  typedef enum logic [5:0] {
    ST_IDLE   = 6'b000001,
    ST_ACCESS = 6'b000010,
    ST_PDOWN  = 6'b000100,
    ST_SREF   = 6'b001000,
    ST_CSUSP  = 6'b010000,
    ST_RECOV  = 6'b100000
  } pwr_state_t;

endpackage

// File: rtl/cke_cmd_classify.sv
module cke_cmd_classify
  import cke_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic [2:0] cmd,
  output cke_pair_t  pair,
  output cmd_class_t cls
);

  logic cke_last;

  always_ff @(posedge clk) begin
    if (rst) cke_last <= 1'b1;
    else     cke_last <= cke;
  end

  always_comb begin
    pair = cke_pair_t'({cke_last, cke});
    unique case (cmd)
      CMD_INHIBIT: cls = CC_INHIBIT;
      CMD_NOP:     cls = CC_NOP;
      CMD_AREF:    cls = CC_AREF;
      default:     cls = CC_OTHER;
    endcase
  end

  // R1/R2: the stored half of the pair follows the level of the edge before
  p_prev_sample_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pair[1] == $past(cke)));

endmodule

// File: rtl/xsr_recovery_timer.sv
module xsr_recovery_timer
  import cke_pwr_pkg::*;
#(
  parameter int TXSR_CYC = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       tick,
  input  cmd_class_t cls,
  output logic       done,
  output logic       viol
);

  localparam int CNT_W = $clog2(TXSR_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TXSR_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       nops;
  logic [1:0]       nops_nx;
  logic             quiet;
  logic             is_nop;

  always_comb begin
    is_nop  = (cls == CC_NOP);
    quiet   = (cls == CC_NOP) || (cls == CC_INHIBIT);
    nops_nx = (is_nop && nops != 2'd2) ? nops + 2'd1 : nops;
    done    = tick && (cnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      nops <= '0;
      viol <= 1'b0;
    end else begin
      if (load) begin
        cnt  <= CNT_INIT;
        nops <= '0;
      end else if (tick) begin
        cnt  <= cnt - CNT_LAST;
        nops <= nops_nx;
        if (!quiet || (done && nops_nx != 2'd2)) viol <= 1'b1;
      end
    end
  end

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == CNT_INIT));

  p_viol_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);

  p_busy_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && cls == CC_AREF) |=> viol);

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import cke_pwr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  cke_pair_t            pair,
  input  cmd_class_t           cls,
  input  logic                 access_active,
  input  logic                 recov_done,
  output pwr_state_t           state,
  output logic                 recov_load,
  output logic                 recov_tick,
  output logic [NUM_MODES-1:0] enter_evt,
  output logic [NUM_MODES-1:0] exit_evt,
  output logic                 illegal
);

  pwr_state_t           state_nx;
  logic [NUM_MODES-1:0] enter_nx;
  logic [NUM_MODES-1:0] exit_nx;
  logic                 bad;
  logic                 quiet;

  always_comb begin
    quiet      = (cls == CC_NOP) || (cls == CC_INHIBIT);
    state_nx   = state;
    enter_nx   = '0;
    exit_nx    = '0;
    bad        = 1'b0;
    recov_load = 1'b0;
    recov_tick = 1'b0;
    unique case (pair)
      PAIR_LL: begin
        if (!(state inside {ST_PDOWN, ST_SREF, ST_CSUSP})) bad = 1'b1;
      end
      PAIR_LH: begin
        if (state == ST_PDOWN && quiet) begin
          state_nx       = ST_IDLE;
          exit_nx[EV_PD] = 1'b1;
        end else if (state == ST_SREF && quiet) begin
          state_nx       = ST_RECOV;
          exit_nx[EV_SR] = 1'b1;
          recov_load     = 1'b1;
        end else if (state == ST_CSUSP) begin
          state_nx       = ST_ACCESS;
          exit_nx[EV_CS] = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      PAIR_HL: begin
        if (state == ST_IDLE && quiet) begin
          state_nx        = ST_PDOWN;
          enter_nx[EV_PD] = 1'b1;
        end else if (state == ST_IDLE && cls == CC_AREF) begin
          state_nx        = ST_SREF;
          enter_nx[EV_SR] = 1'b1;
        end else if (state == ST_ACCESS && cls != CC_INHIBIT) begin
          state_nx        = ST_CSUSP;
          enter_nx[EV_CS] = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      PAIR_HH: begin
        if (state inside {ST_IDLE, ST_ACCESS}) begin
          state_nx = access_active ? ST_ACCESS : ST_IDLE;
        end else if (state == ST_RECOV) begin
          recov_tick = 1'b1;
          if (recov_done) state_nx = ST_IDLE;
        end else begin
          bad = 1'b1;
        end
      end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      enter_evt <= '0;
      exit_evt  <= '0;
      illegal   <= 1'b0;
    end else begin
      state     <= state_nx;
      enter_evt <= enter_nx;
      exit_evt  <= exit_nx;
      if (bad) illegal <= 1'b1;
    end
  end

  p_ll_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (pair == PAIR_LL && state inside {ST_PDOWN, ST_SREF, ST_CSUSP})
    |=> (state == $past(state)));

  p_pd_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PDOWN && pair == PAIR_LH && quiet) |=> (state == ST_IDLE));

  p_sr_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && pair == PAIR_HL && cls == CC_AREF)
    |=> (state == ST_SREF && enter_evt[EV_SR]));

  p_cs_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CSUSP && pair == PAIR_LH) |=> (state == ST_ACCESS));

  p_illegal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  p_evt_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({enter_evt, exit_evt}));

endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
  import cke_pwr_pkg::*;
#(
  parameter int TXSR_CYC = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       access_active,
  output logic [5:0] pwr_state,
  output logic [2:0] enter_evt,
  output logic [2:0] exit_evt,
  output logic       illegal_seq,
  output logic       xsr_violation
);

  cke_pair_t  pair;
  cmd_class_t cls;
  pwr_state_t state;
  logic       recov_load;
  logic       recov_tick;
  logic       recov_done;

  cke_cmd_classify u_classify (
    .clk  (clk),
    .rst  (rst),
    .cke  (cke),
    .cmd  (cmd),
    .pair (pair),
    .cls  (cls)
  );

  xsr_recovery_timer #(.TXSR_CYC(TXSR_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (recov_load),
    .tick (recov_tick),
    .cls  (cls),
    .done (recov_done),
    .viol (xsr_violation)
  );

  pwr_state_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .pair          (pair),
    .cls           (cls),
    .access_active (access_active),
    .recov_done    (recov_done),
    .state         (state),
    .recov_load    (recov_load),
    .recov_tick    (recov_tick),
    .enter_evt     (enter_evt),
    .exit_evt      (exit_evt),
    .illegal       (illegal_seq)
  );

  assign pwr_state = state;

  p_recov_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 6'b100000 && recov_done) |=> (pwr_state == 6'b000001));

endmodule

// File: tb/sdram_cke_tracker_tb_top.sv
module sdram_cke_tracker_tb_top;

  localparam int TXSR = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic [2:0] cmd = 3'd1;
  logic       access_active = 1'b0;
  logic [5:0] pwr_state;
  logic [2:0] enter_evt;
  logic [2:0] exit_evt;
  logic       illegal_seq;
  logic       xsr_violation;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  // reference model state
  logic [5:0] m_st;
  logic       m_prev;
  int         m_cnt;
  int         m_nops;
  logic       m_ill, m_viol;
  logic [2:0] m_en, m_ex;
  string      m_tag;

  localparam logic [5:0] S_IDLE = 6'b000001, S_ACC = 6'b000010, S_PD = 6'b000100,
                         S_SR = 6'b001000, S_CS = 6'b010000, S_REC = 6'b100000;

  always #10 clk = ~clk;

  sdram_cke_tracker #(.TXSR_CYC(TXSR)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .access_active(access_active),
    .pwr_state(pwr_state), .enter_evt(enter_evt), .exit_evt(exit_evt),
    .illegal_seq(illegal_seq), .xsr_violation(xsr_violation)
  );

  task automatic model_step(input logic r, input logic k, input logic [2:0] c, input logic a);
    logic quiet;
    int n;
    quiet = (c == 3'd0) || (c == 3'd1);
    m_en = '0; m_ex = '0;
    if (r) begin
      m_st = S_IDLE; m_prev = 1'b1; m_cnt = 0; m_nops = 0;
      m_ill = 0; m_viol = 0; m_tag = "R1";
      return;
    end
    case ({m_prev, k})
      2'b00: begin
        m_tag = "R2";
        if (!(m_st == S_PD || m_st == S_SR || m_st == S_CS)) begin m_ill = 1; m_tag = "R9"; end
      end
      2'b01: begin
        if (m_st == S_PD && quiet) begin m_st = S_IDLE; m_ex[0] = 1; m_tag = "R3"; end
        else if (m_st == S_SR && quiet) begin
          m_st = S_REC; m_ex[1] = 1; m_cnt = TXSR; m_nops = 0; m_tag = "R5";
        end
        else if (m_st == S_CS) begin m_st = S_ACC; m_ex[2] = 1; m_tag = "R7"; end
        else begin m_ill = 1; m_tag = "R9"; end
      end
      2'b10: begin
        if (m_st == S_IDLE && quiet) begin m_st = S_PD; m_en[0] = 1; m_tag = "R3"; end
        else if (m_st == S_IDLE && c == 3'd2) begin m_st = S_SR; m_en[1] = 1; m_tag = "R4"; end
        else if (m_st == S_ACC && c != 3'd0) begin m_st = S_CS; m_en[2] = 1; m_tag = "R7"; end
        else begin m_ill = 1; m_tag = "R9"; end
      end
      default: begin
        if (m_st == S_IDLE || m_st == S_ACC) begin
          m_st = a ? S_ACC : S_IDLE; m_tag = "R8";
        end else if (m_st == S_REC) begin
          m_tag = "R5";
          if (!quiet) begin m_viol = 1; m_tag = "R6"; end
          n = m_nops + ((c == 3'd1) ? 1 : 0);
          if (m_cnt == 1) begin
            if (n < 2) begin m_viol = 1; m_tag = "R6"; end
            m_st = S_IDLE;
          end
          m_cnt = m_cnt - 1; m_nops = n;
        end else begin m_ill = 1; m_tag = "R9"; end
      end
    endcase
    m_prev = k;
  endtask

  task automatic compare();
    checks++;
    if (pwr_state !== m_st) begin
      failures++;
      $display("FAIL %s state actual=%b expected=%b", m_tag, pwr_state, m_st);
    end
    checks++;
    if (enter_evt !== m_en || exit_evt !== m_ex) begin
      failures++;
      $display("FAIL R10 (%s) events actual=%b/%b expected=%b/%b", m_tag,
               enter_evt, exit_evt, m_en, m_ex);
    end
    checks++;
    if (illegal_seq !== m_ill) begin
      failures++;
      $display("FAIL R9 (%s) illegal actual=%b expected=%b", m_tag, illegal_seq, m_ill);
    end
    checks++;
    if (xsr_violation !== m_viol) begin
      failures++;
      $display("FAIL R6 (%s) violation actual=%b expected=%b", m_tag, xsr_violation, m_viol);
    end
  endtask

  task automatic step(input logic r, input logic k, input logic [2:0] c, input logic a);
    @(negedge clk);
    rst = r; cke = k; cmd = c; access_active = a;
    model_step(r, k, c, a);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic expect_state(input logic [5:0] exp, input string tag);
    checks++;
    if (pwr_state !== exp) begin
      failures++;
      $display("FAIL %s directed state actual=%b expected=%b", tag, pwr_state, exp);
    end
  endtask

  initial begin
    // R1: reset
    step(1, 1, 3'd1, 0);
    step(1, 1, 3'd1, 0);
    expect_state(S_IDLE, "R1");
    // R1/R3: first edge low after reset enters power-down
    step(0, 0, 3'd0, 0);
    expect_state(S_PD, "R3");
    // R2: hold with auto refresh on bus
    step(0, 0, 3'd2, 0);
    step(0, 0, 3'd5, 0);
    expect_state(S_PD, "R2");
    step(0, 1, 3'd1, 0);  // R3 exit
    expect_state(S_IDLE, "R3");
    // R4/R5: self refresh, clean recovery with NOPs
    step(0, 0, 3'd2, 0);
    expect_state(S_SR, "R4");
    step(0, 0, 3'd3, 0);
    step(0, 1, 3'd0, 0);
    expect_state(S_REC, "R5");
    for (int i = 0; i < TXSR; i++) step(0, 1, (i % 2 == 0) ? 3'd1 : 3'd0, 0);
    expect_state(S_IDLE, "R5");
    // R6: only one NOP in the window
    step(0, 0, 3'd2, 0);
    step(0, 1, 3'd1, 0);
    for (int i = 0; i < TXSR; i++) step(0, 1, (i == 0) ? 3'd1 : 3'd0, 0);
    // R6: busy command inside the window
    step(1, 1, 3'd1, 0);
    step(0, 0, 3'd2, 0);
    step(0, 1, 3'd1, 0);
    step(0, 1, 3'd1, 0);
    step(0, 1, 3'd4, 0);
    for (int i = 0; i < TXSR; i++) step(0, 1, 3'd1, 0);
    // R7/R8: access, clock suspend, exit
    step(1, 1, 3'd1, 0);
    step(0, 1, 3'd3, 1);
    expect_state(S_ACC, "R8");
    step(0, 0, 3'd3, 1);
    expect_state(S_CS, "R7");
    step(0, 0, 3'd0, 1);
    step(0, 1, 3'd6, 1);
    expect_state(S_ACC, "R7");
    step(0, 1, 3'd1, 0);
    expect_state(S_IDLE, "R8");
    // R9: inhibit in access with falling CKE, then power-down with HH
    step(0, 1, 3'd1, 1);
    step(0, 0, 3'd0, 1);
    step(1, 1, 3'd1, 0);
    step(0, 0, 3'd1, 0);
    step(0, 1, 3'd3, 0);
    step(0, 1, 3'd1, 0);
    // constrained random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic k;
      logic [2:0] c;
      int p, q;
      p = $urandom_range(0, 99);
      q = $urandom_range(0, 99);
      if (m_st == S_REC) k = (p < 97);
      else if (m_st == S_PD || m_st == S_SR || m_st == S_CS) k = (p < 30);
      else k = (p < 80);
      if (m_st == S_REC) c = (q < 60) ? 3'd1 : (q < 95) ? 3'd0 : 3'($urandom_range(2, 7));
      else if (q < 50) c = 3'($urandom_range(0, 1));
      else if (q < 65) c = 3'd2;
      else c = 3'($urandom_range(3, 7));
      step((i % 150) == 0, k, c, 1'($urandom_range(0, 1)));
    end
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule